// File: doc/BRIEF.md
# Channel Status Block Double Buffer

This block gathers the channel status bits that a digital audio receiver recovers, one bit per subframe. Each incoming bit carries a channel tag (A or B) and, on the first bit of a block, a block-start marker. The bits go into a private working buffer, 192 bits per channel. Once a complete block has arrived for both channels, both channels are copied in one cycle into a host-visible buffer. The host always sees whole blocks and never a mix of two blocks.

The host reads the visible buffer one byte at a time through a registered read port at addresses 0x20 to 0x37. A select pin picks which channel those addresses return. A sticky flag tells the host that something new has been published. In one mode the flag rises on every published block. In the other mode it rises only when the first five bytes of the selected channel differ from the copy published before.

The bit stream enters over a valid/ready handshake. A beat is taken on a clock edge where `s_valid` and `s_ready` are both high. The source must hold its beat stable while `s_ready` is low. `s_ready` goes low only while a finished block waits to be copied. The copy is never made in a cycle with a host read, so the wait lasts for as long as `rd_en` stays high. Control and status pins have no handshake.

Top module: `chstat_dbuf`

## Requirements
- R1: After reset `s_ready` is 1. It drops only when both channels hold 192 bits, and it returns on the edge that performs the copy. A beat is consumed only on an edge where `s_valid` and `s_ready` are both 1.
- R2: Bit n of a channel's block (n = 0..191, bit 0 first in time) is placed at bit n mod 8 of byte n/8. Byte k is read at address 0x20 + k.
- R3: Collection starts on a channel A beat (`s_chan` = 0) that has `s_start` = 1. Before the first such beat, and after each copy until the next such beat, beats are consumed and discarded. `s_start` on a channel B beat (`s_chan` = 1) does not mark a block start.
- R4: A channel A start beat that arrives while a block is partly collected discards the partial block, begins a new block with that beat as bit 0, and publishes nothing.
- R5: The visible buffer changes only when 192 bits of channel A and 192 bits of channel B have been collected. Both channels are then replaced together.
- R6: Reads return channel A bytes when `sel_b` = 0 and channel B bytes when `sel_b` = 1, with `sel_b` sampled in the read cycle.
- R7: `rd_data` shows the addressed byte in the cycle after `rd_en` is sampled high and holds its value otherwise. Addresses outside 0x20..0x37 read as 0.
- R8: The copy is delayed for as long as `rd_en` is high, so the visible buffer never changes on an edge that samples a read.
- R9: With `flag_mode` = 0, `flag` is set on every copy.
- R10: With `flag_mode` = 1, a copy sets `flag` only if bits 0..39 of the channel chosen by `sel_b` differ from the same bits of that channel's previously visible block. The visible buffer is all zero after reset.
- R11: `flag` stays set until a cycle with `flag_clr` = 1. A copy that sets the flag in the same cycle wins over the clear.
- R12: After reset `flag` is 0 and every byte of the visible buffer reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Status bit beat is valid |
| s_ready | output | 1 | Block accepts a beat |
| s_bit | input | 1 | Channel status bit value |
| s_chan | input | 1 | Channel tag, 0 = A, 1 = B |
| s_start | input | 1 | Block-start marker (meaningful on channel A) |
| sel_b | input | 1 | Read channel select, 0 = A, 1 = B |
| flag_mode | input | 1 | 0 = flag on every block, 1 = flag on change of first five bytes |
| flag_clr | input | 1 | Clear the sticky flag |
| flag | output | 1 | Sticky new-status flag |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Read data, one cycle after the strobe |

## Verification
If a collection counter goes wrong, the fault shows up as a byte that appears one bit position off when the host reads it. It can also show up as a copy that never happens, so `s_ready` stays low and the flag never rises. Either effect is visible within one block time, about 384 beats. A fault in the copy gating shows up at once: a read held across a block's completion returns new data, or the flag rises too early. A fault in the compare register shows up at the first publish in change mode, when the flag is set or missed against the five-byte rule.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
  localparam int unsigned CS_BITS   = 192;
  localparam int unsigned CS_BYTES  = CS_BITS / 8;
  localparam int unsigned CMP_BYTES = 5;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned BASE_ADDR = 32'h20;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;
endpackage

// File: rtl/cs_collect.sv
module cs_collect
  import chstat_pkg::*;
#(
  parameter int unsigned NBITS = CS_BITS,
  localparam int unsigned CW   = $clog2(NBITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_chan,
  input  logic             in_start,
  output logic             in_ready,
  input  logic             copy_done,
  output logic             complete,
  output logic [NBITS-1:0] work_a,
  output logic [NBITS-1:0] work_b,
  output logic [CW-1:0]    cnt_a,
  output logic [CW-1:0]    cnt_b
);
  localparam logic [CW-1:0] FULL = CW'(NBITS);

  logic synced;
  logic accept;
  logic is_a;

  assign complete = (cnt_a == FULL) && (cnt_b == FULL);
  assign in_ready = !complete;
  assign accept   = in_valid && in_ready;
  assign is_a     = (chan_e'(in_chan) == CH_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
      work_a <= '0;
      work_b <= '0;
    end else if (copy_done) begin
      synced <= 1'b0;
      cnt_a  <= '0;
      cnt_b  <= '0;
    end else if (accept) begin
      if (is_a && in_start) begin
        // a new block begins here; any partial block is dropped
        synced    <= 1'b1;
        work_a[0] <= in_bit;
        cnt_a     <= CW'(1);
        cnt_b     <= '0;
      end else if (synced) begin
        if (is_a && cnt_a < FULL) begin
          work_a[cnt_a] <= in_bit;
          cnt_a         <= cnt_a + 1'b1;
        end else if (!is_a && cnt_b < FULL) begin
          work_b[cnt_b] <= in_bit;
          cnt_b         <= cnt_b + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cs_publish.sv
module cs_publish
  import chstat_pkg::*;
#(
  parameter int unsigned NBITS = CS_BITS,
  parameter int unsigned NCMP  = CMP_BYTES,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned BASE  = BASE_ADDR,
  localparam int unsigned NBYTES = NBITS / 8,
  localparam int unsigned CMPB   = NCMP * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             complete,
  input  logic [NBITS-1:0] work_a,
  input  logic [NBITS-1:0] work_b,
  input  logic             sel_b,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic             copy_evt,
  output logic             changed,
  output logic [NBITS-1:0] pub_a,
  output logic [NBITS-1:0] pub_b,
  output logic [7:0]       rd_data
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + NBYTES);

  logic [AW-1:0]    off;
  logic             in_win;
  logic [NBITS-1:0] src;

  // a pending block waits for a cycle free of host reads
  assign copy_evt = complete && !rd_en;

  assign changed = sel_b ? (work_b[CMPB-1:0] != pub_b[CMPB-1:0])
                         : (work_a[CMPB-1:0] != pub_a[CMPB-1:0]);

  assign off    = rd_addr - LO;
  assign in_win = (rd_addr >= LO) && (rd_addr < HI);
  assign src    = sel_b ? pub_b : pub_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pub_a <= '0;
      pub_b <= '0;
    end else if (copy_evt) begin
      pub_a <= work_a;
      pub_b <= work_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= in_win ? src[8*int'(off) +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/cs_flag.sv
module cs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic copy_evt,
  input  logic on_change,
  input  logic changed,
  input  logic clr,
  output logic flag
);
  logic set;

  assign set = copy_evt && (!on_change || changed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/chstat_dbuf.sv
module chstat_dbuf
  import chstat_pkg::*;
#(
  parameter int unsigned NBITS = CS_BITS,
  parameter int unsigned NCMP  = CMP_BYTES,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned BASE  = BASE_ADDR,
  localparam int unsigned CW   = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_bit,
  input  logic          s_chan,
  input  logic          s_start,
  input  logic          sel_b,
  input  logic          flag_mode,
  input  logic          flag_clr,
  output logic          flag,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic             complete;
  logic             copy_evt;
  logic             changed;
  logic [NBITS-1:0] work_a, work_b;
  logic [NBITS-1:0] pub_a, pub_b;
  logic [CW-1:0]    cnt_a, cnt_b;

  cs_collect #(.NBITS(NBITS)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_valid),
    .in_bit    (s_bit),
    .in_chan   (s_chan),
    .in_start  (s_start),
    .in_ready  (s_ready),
    .copy_done (copy_evt),
    .complete  (complete),
    .work_a    (work_a),
    .work_b    (work_b),
    .cnt_a     (cnt_a),
    .cnt_b     (cnt_b)
  );

  cs_publish #(.NBITS(NBITS), .NCMP(NCMP), .AW(AW), .BASE(BASE)) u_publish (
    .clk      (clk),
    .rst_n    (rst_n),
    .complete (complete),
    .work_a   (work_a),
    .work_b   (work_b),
    .sel_b    (sel_b),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .copy_evt (copy_evt),
    .changed  (changed),
    .pub_a    (pub_a),
    .pub_b    (pub_b),
    .rd_data  (rd_data)
  );

  cs_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .copy_evt  (copy_evt),
    .on_change (flag_mode),
    .changed   (changed),
    .clr       (flag_clr),
    .flag      (flag)
  );
endmodule

// File: rtl/chstat_dbuf_chk.sv
module chstat_dbuf_chk #(
  parameter int unsigned NBITS = 192,
  parameter int unsigned AW    = 8,
  parameter int unsigned BASE  = 32'h20,
  localparam int unsigned CW   = $clog2(NBITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_ready,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [7:0]       rd_data,
  input logic             flag,
  input logic             flag_clr,
  input logic             copy_evt,
  input logic [NBITS-1:0] pub_a,
  input logic [NBITS-1:0] pub_b,
  input logic [CW-1:0]    cnt_a,
  input logic [CW-1:0]    cnt_b
);
  localparam logic [CW-1:0] FULL = CW'(NBITS);
  localparam logic [AW-1:0] LO   = AW'(BASE);
  localparam logic [AW-1:0] HI   = AW'(BASE + NBITS / 8);

  logic oob;
  assign oob = (rd_addr < LO) || (rd_addr >= HI);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= FULL) && (cnt_b <= FULL));

  assert_copy_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_evt |=> (cnt_a == '0) && (cnt_b == '0));

  assert_no_copy_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ($stable(pub_a) && $stable(pub_b)));

  assert_ready_returns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !rd_en) |=> s_ready);

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !copy_evt) |=> !flag);

  assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(copy_evt));

  assert_oob_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && oob) |=> (rd_data == 8'h00));
endmodule

bind chstat_dbuf chstat_dbuf_chk #(.NBITS(NBITS), .AW(AW), .BASE(BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_ready  (s_ready),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .flag     (flag),
  .flag_clr (flag_clr),
  .copy_evt (copy_evt),
  .pub_a    (pub_a),
  .pub_b    (pub_b),
  .cnt_a    (cnt_a),
  .cnt_b    (cnt_b)
);

// File: tb/chstat_dbuf_test.sv
`timescale 1ns/1ps
module chstat_dbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_bit = 1'b0, s_chan = 1'b0, s_start = 1'b0;
  logic       s_ready;
  logic       sel_b = 1'b0, flag_mode = 1'b0, flag_clr = 1'b0;
  logic       flag;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [191:0] mod_a = '0, mod_b = '0;
  logic [7:0]   exp_q[$];
  string        tag_q[$];
  logic         rd_pend = 1'b0;

  always #2.5 clk = ~clk;

  chstat_dbuf uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_bit(s_bit), .s_chan(s_chan), .s_start(s_start), .sel_b(sel_b),
    .flag_mode(flag_mode), .flag_clr(flag_clr), .flag(flag),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: pops one expected byte per completed read
  always @(negedge clk) begin
    if (rd_pend) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL read with no expected entry: actual %02h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          mismatched++;
          $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] a, input bit b);
    if (a < 8'h20 || a > 8'h37) return 8'h00;
    return b ? mod_b[8*int'(a - 8'h20) +: 8] : mod_a[8*int'(a - 8'h20) +: 8];
  endfunction

  // driver side of the scoreboard: issue read, push expectation
  task automatic rd(input logic [7:0] a, input bit b, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a; sel_b = b;
    exp_q.push_back(exp_byte(a, b));
    tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0; sel_b = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k < 24; k++) begin
      rd(8'h20 + 8'(k), 1'b0, req);
      rd(8'h20 + 8'(k), 1'b1, req);
    end
  endtask

  // caller is at a negedge; returns at the negedge after acceptance
  task automatic beat(input bit v, input bit ch, input bit st);
    s_valid = 1'b1; s_bit = v; s_chan = ch; s_start = st;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_start = 1'b0;
  endtask

  task automatic send_frames(input logic [191:0] a, input logic [191:0] b, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      beat(a[i], 1'b0, i == 0);
      beat(b[i], 1'b1, 1'b0);
    end
  endtask

  function automatic logic [191:0] rnd192();
    logic [191:0] r;
    for (int w = 0; w < 6; w++) r[32*w +: 32] = $urandom;
    return r;
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [191:0] a, b, x;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 / R1: reset state
    check(flag == 1'b0, "R12 flag after reset", flag, 0);
    check(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
    rd(8'h20, 1'b0, "R12 zero buffer A");
    rd(8'h37, 1'b1, "R12 zero buffer B");

    // R3: beats before any start marker, and start on channel B, are dropped
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      beat(1'b1, 1'b0, 1'b0);
      beat(1'b1, 1'b1, 1'b1);
    end

    // R2 R5 R6 R9: first full block, mode 0
    a = rnd192(); b = rnd192();
    send_frames(a, b, 192);
    settle();
    mod_a = a; mod_b = b;
    check(flag == 1'b1, "R9 flag on block (mode 0)", flag, 1);
    read_all("R2/R6 block 1 bytes");

    // R7: outside the window
    rd(8'h1f, 1'b0, "R7 below window");
    rd(8'h38, 1'b1, "R7 above window");
    rd(8'hff, 1'b0, "R7 top address");

    // R11: clear
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    check(flag == 1'b0, "R11 flag cleared", flag, 0);
    repeat (2) @(negedge clk);
    check(flag == 1'b0, "R11 flag stays clear", flag, 0);

    // R4: partial block then restart; R3 trailing beats after copy ignored
    x = rnd192();
    send_frames(x, ~x, 100);
    check(flag == 1'b0, "R5 no publish for partial block", flag, 0);
    a = rnd192(); b = rnd192();
    send_frames(a, b, 192);
    settle();
    mod_a = a; mod_b = b;
    check(flag == 1'b1, "R4 restarted block published", flag, 1);
    read_all("R4 restarted block bytes");
    @(negedge clk);
    for (int i = 0; i < 6; i++) beat(1'b1, i[0], 1'b0);
    settle();
    rd(8'h20, 1'b0, "R3 stray beats after copy ignored");
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // R10: change mode, first five bytes of A unchanged
    flag_mode = 1'b1;
    a = {rnd192()} ; a[39:0] = mod_a[39:0];
    b = rnd192();
    send_frames(a, b, 192);
    settle();
    mod_a = a; mod_b = b;
    check(flag == 1'b0, "R10 no flag when first five bytes equal", flag, 0);
    rd(8'h2a, 1'b0, "R10 later bytes still published");
    rd(8'h30, 1'b1, "R10 channel B published");

    // R10: only channel B differs in first bytes while A selected
    a = mod_a; b = mod_b; b[7:0] = ~mod_b[7:0];
    send_frames(a, b, 192);
    settle();
    mod_b = b;
    check(flag == 1'b0, "R10 unselected channel change ignored", flag, 0);
    rd(8'h20, 1'b1, "R10 B byte 0 updated");

    // R10: selected channel differs at bit 17
    a = mod_a; a[17] = ~a[17];
    send_frames(a, mod_b, 192);
    settle();
    mod_a = a;
    check(flag == 1'b1, "R10 flag on first-five-byte change", flag, 1);
    rd(8'h22, 1'b0, "R2 byte 2 with bit 17 flipped");
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    flag_mode = 1'b0;

    // R8 R1: read held across block completion defers the copy
    a = rnd192(); b = rnd192();
    send_frames(a, b, 191);
    beat(a[191], 1'b0, 1'b0);
    rd_en = 1'b1; rd_addr = 8'h20; sel_b = 1'b0;
    exp_q.push_back(mod_a[7:0]); tag_q.push_back("R8 old data during held read");
    s_valid = 1'b1; s_bit = b[191]; s_chan = 1'b1; s_start = 1'b0;
    @(negedge clk);
    s_valid = 1'b0;
    exp_q.push_back(mod_a[7:0]); tag_q.push_back("R8 old data during held read");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      exp_q.push_back(mod_a[7:0]); tag_q.push_back("R8 old data during held read");
      check(flag == 1'b0, "R8 flag waits for read to end", flag, 0);
      check(s_ready == 1'b0, "R1 back-pressure while copy pending", s_ready, 0);
    end
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    mod_a = a; mod_b = b;
    check(flag == 1'b1, "R8 copy after read ends", flag, 1);
    check(s_ready == 1'b1, "R1 ready after copy", s_ready, 1);
    rd(8'h20, 1'b0, "R8 new data after copy");
    rd(8'h37, 1'b1, "R8 new data after copy B");

    // R11: set wins over clear in the same cycle
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    send_frames(a, b, 191);
    beat(a[191], 1'b0, 1'b0);
    s_valid = 1'b1; s_bit = b[191]; s_chan = 1'b1;
    @(negedge clk);
    s_valid = 1'b0; flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(flag == 1'b1, "R11 set wins over clear", flag, 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule